// File: doc/BRIEF.md
# Coprocessor Handshake Controller

This block is the processor-side sequencer that runs when the core issues an instruction meant for an external coprocessor. On an issue strobe it pulls an active-low request line low and holds the core's pipeline through a stall output. While the request stays low it samples two inputs from the coprocessor side on every clock edge. The first says no coprocessor has taken the instruction. The second says the accepting coprocessor is not yet ready to start.

If nobody accepts the instruction, the handshake is abandoned and a one-cycle undefined-instruction trap request goes to the core. If a coprocessor accepts and is busy, the controller keeps the request low and waits for as long as it takes. When busy drops, a one-cycle completion pulse is given. The same trap is taken if the absent line rises during the wait, which means the coprocessor has withdrawn. A build-time limit can also force the trap after a fixed number of wait cycles. The limit is off by default.

Each clock edge stands for the end of the sampling phase of a bus cycle. The inputs are expected to be settled before that edge.

Top module: `cp_handshake_ctrl`

## Requirements
- R1: When `issue_i` is high in an idle cycle, `cp_req_n_o` is low and `stall_o` is high from the next cycle on.
- R2: If `cp_absent_i` is high at the edge that ends the first request cycle, the next cycle has `undef_trap_o` high and `done_o` low.
- R3: If `cp_absent_i` is high at any edge during the busy-wait, the next cycle has `undef_trap_o` high.
- R4: While the request is low with `cp_absent_i` low and `cp_busy_i` high, the request and the stall both stay asserted and no result is given. With `TIMEOUT_CYCLES` = 0 this holds for any number of cycles.
- R5: When `cp_absent_i` and `cp_busy_i` are both low at an edge while the request is low, the next cycle has `done_o` high and `undef_trap_o` low.
- R6: `done_o` and `undef_trap_o` each last exactly one cycle. In that cycle `cp_req_n_o` is high and `stall_o` is low, and the cycle after it is idle.
- R7: `issue_i` has no effect while a handshake is in progress or in its result cycle: no second request starts and exactly one result pulse is given.
- R8: With `TIMEOUT_CYCLES` = N > 0, a handshake that has spent N cycles in busy-wait with busy still high gives `undef_trap_o` in the next cycle.
- R9: During and right after reset, `cp_req_n_o` is high and `stall_o`, `done_o` and `undef_trap_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; each rising edge is the sampling point |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Core issues a coprocessor instruction |
| cp_absent_i | input | 1 | High: no coprocessor has accepted the instruction |
| cp_busy_i | input | 1 | High: the accepting coprocessor cannot start yet |
| cp_req_n_o | output | 1 | Active-low coprocessor instruction request |
| stall_o | output | 1 | Holds the core pipeline while the handshake runs |
| done_o | output | 1 | One-cycle completion pulse |
| undef_trap_o | output | 1 | One-cycle undefined-instruction trap request |

## Verification
Every result is registered once. The request and the stall appear in the cycle after the issue edge. The trap or completion pulse appears in the cycle after the edge that samples the deciding absent/busy pair, and the block is idle again one cycle after that. The bench drives inputs and samples outputs on the falling edge, so each check reads the state left by exactly the rising edges counted in its task. A second instance built with a timeout of four is used to check the forced trap. It must trap after its fourth busy-wait cycle while the default instance keeps waiting under the same stimulus.

// File: rtl/cph_pkg.sv
package cph_pkg;

   typedef enum logic [2:0] {
      CPH_IDLE = 3'd0,
      CPH_REQ  = 3'd1,
      CPH_WAIT = 3'd2,
      CPH_DONE = 3'd3,
      CPH_TRAP = 3'd4
   } cph_state_t;

   localparam int unsigned CPH_TIMEOUT_MAX = 65535;

endpackage

// File: rtl/cph_timeout.sv
module cph_timeout #(
   parameter int unsigned LIMIT = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic waiting_i,
   output logic expire_o
);

   localparam int unsigned CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

   generate
      if (LIMIT == 0) begin : g_off
         logic unused_tie;
         assign unused_tie = ^{clk, rst_n, waiting_i};
         assign expire_o   = 1'b0;
      end else begin : g_on
         localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (!waiting_i) begin
               cnt_q <= '0;
            end else if (cnt_q != LAST) begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign expire_o = waiting_i && (cnt_q == LAST);
      end
   endgenerate

endmodule

// File: rtl/cph_fsm.sv
module cph_fsm
   import cph_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       issue_i,
   input  logic       absent_i,
   input  logic       busy_i,
   input  logic       expire_i,
   output cph_state_t state_o
);

   cph_state_t state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         CPH_IDLE: if (issue_i) state_d = CPH_REQ;
         CPH_REQ: begin
            if (absent_i)     state_d = CPH_TRAP;
            else if (!busy_i) state_d = CPH_DONE;
            else              state_d = CPH_WAIT;
         end
         CPH_WAIT: begin
            if (absent_i)      state_d = CPH_TRAP;
            else if (!busy_i)  state_d = CPH_DONE;
            else if (expire_i) state_d = CPH_TRAP;
            else               state_d = CPH_WAIT;
         end
         CPH_DONE: state_d = CPH_IDLE;
         CPH_TRAP: state_d = CPH_IDLE;
         default:  state_d = CPH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= CPH_IDLE;
      else        state_q <= state_d;
   end

   assign state_o = state_q;

endmodule

// File: rtl/cph_outdec.sv
module cph_outdec
   import cph_pkg::*;
(
   input  cph_state_t state_i,
   output logic       req_n_o,
   output logic       stall_o,
   output logic       waiting_o,
   output logic       done_o,
   output logic       trap_o
);

   logic active;

   assign active    = (state_i == CPH_REQ) || (state_i == CPH_WAIT);
   assign req_n_o   = !active;
   assign stall_o   = active;
   assign waiting_o = (state_i == CPH_WAIT);
   assign done_o    = (state_i == CPH_DONE);
   assign trap_o    = (state_i == CPH_TRAP);

endmodule

// File: rtl/cp_handshake_ctrl.sv
module cp_handshake_ctrl
   import cph_pkg::*;
#(
   parameter int unsigned TIMEOUT_CYCLES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic issue_i,
   input  logic cp_absent_i,
   input  logic cp_busy_i,
   output logic cp_req_n_o,
   output logic stall_o,
   output logic done_o,
   output logic undef_trap_o
);

   generate
      if (TIMEOUT_CYCLES > CPH_TIMEOUT_MAX) begin : g_bad_limit
         $error("cp_handshake_ctrl: TIMEOUT_CYCLES above supported maximum");
      end
   endgenerate

   cph_state_t state;
   logic       waiting;
   logic       expire;

   cph_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .issue_i  (issue_i),
      .absent_i (cp_absent_i),
      .busy_i   (cp_busy_i),
      .expire_i (expire),
      .state_o  (state)
   );

   cph_timeout #(.LIMIT(TIMEOUT_CYCLES)) u_tmo (
      .clk       (clk),
      .rst_n     (rst_n),
      .waiting_i (waiting),
      .expire_o  (expire)
   );

   cph_outdec u_dec (
      .state_i   (state),
      .req_n_o   (cp_req_n_o),
      .stall_o   (stall_o),
      .waiting_o (waiting),
      .done_o    (done_o),
      .trap_o    (undef_trap_o)
   );

endmodule

// File: rtl/cph_checker.sv
module cph_checker (
   input logic clk,
   input logic rst_n,
   input logic issue_i,
   input logic cp_absent_i,
   input logic cp_busy_i,
   input logic cp_req_n_o,
   input logic stall_o,
   input logic done_o,
   input logic undef_trap_o
);

   assert_req_on_issue_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_req_n_o && !done_o && !undef_trap_o && issue_i) |=> (!cp_req_n_o && stall_o));

   assert_trap_on_absent_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cp_req_n_o && cp_absent_i) |=> (undef_trap_o && !done_o));

   assert_wait_no_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cp_req_n_o && !cp_absent_i && cp_busy_i) |=> !done_o);

   assert_done_on_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!cp_req_n_o && !cp_absent_i && !cp_busy_i) |=> (done_o && !undef_trap_o));

   assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!done_o && !undef_trap_o && cp_req_n_o));

   assert_trap_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      undef_trap_o |=> (!undef_trap_o && !done_o && cp_req_n_o));

   assert_result_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done_o, undef_trap_o, stall_o}));

   assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cp_req_n_o && $past(!cp_req_n_o)) |-> $stable(stall_o));

endmodule

bind cp_handshake_ctrl cph_checker u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .issue_i      (issue_i),
   .cp_absent_i  (cp_absent_i),
   .cp_busy_i    (cp_busy_i),
   .cp_req_n_o   (cp_req_n_o),
   .stall_o      (stall_o),
   .done_o       (done_o),
   .undef_trap_o (undef_trap_o)
);

// File: tb/sim_cp_handshake_ctrl.sv
`timescale 1ns/1ps
module sim_cp_handshake_ctrl;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic issue = 1'b0;
   logic absent = 1'b1;
   logic busy = 1'b0;

   logic req_n0, stall0, done0, trap0;
   logic req_n1, stall1, done1, trap1;

   int n_checks = 0;
   int n_fail   = 0;

   always #2.5 clk = ~clk;

   cp_handshake_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .issue_i(issue), .cp_absent_i(absent),
      .cp_busy_i(busy), .cp_req_n_o(req_n0), .stall_o(stall0),
      .done_o(done0), .undef_trap_o(trap0)
   );

   cp_handshake_ctrl #(.TIMEOUT_CYCLES(4)) u1 (
      .clk(clk), .rst_n(rst_n), .issue_i(issue), .cp_absent_i(absent),
      .cp_busy_i(busy), .cp_req_n_o(req_n1), .stall_o(stall1),
      .done_o(done1), .undef_trap_o(trap1)
   );

   task automatic step();
      @(negedge clk);
   endtask

   // order of bits: {req_n, stall, done, trap}
   task automatic expect0(string tag, logic [3:0] exp);
      logic [3:0] act;
      act = {req_n0, stall0, done0, trap0};
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s u0 {req_n,stall,done,trap} actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic expect1(string tag, logic [3:0] exp);
      logic [3:0] act;
      act = {req_n1, stall1, done1, trap1};
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s u1 {req_n,stall,done,trap} actual=%b expected=%b", tag, act, exp);
      end
   endtask

   localparam logic [3:0] S_IDLE = 4'b1000;
   localparam logic [3:0] S_ACT  = 4'b0100;
   localparam logic [3:0] S_DONE = 4'b1010;
   localparam logic [3:0] S_TRAP = 4'b1001;

   task automatic settle();
      issue = 1'b0; absent = 1'b1; busy = 1'b0;
      repeat (3) step();
   endtask

   task automatic t_reset();
      step();
      expect0("R9 in reset", S_IDLE);
      rst_n = 1'b1;
      step();
      expect0("R9 after reset", S_IDLE);
      expect1("R9 after reset", S_IDLE);
   endtask

   task automatic t_absent_trap();
      issue = 1'b1; step(); issue = 1'b0;
      expect0("R1 request", S_ACT);
      absent = 1'b1; busy = 1'b0;
      step();
      expect0("R2 trap when absent", S_TRAP);
      step();
      expect0("R6 idle after trap", S_IDLE);
      settle();
   endtask

   task automatic t_immediate_done();
      issue = 1'b1; step(); issue = 1'b0;
      expect0("R1 request", S_ACT);
      absent = 1'b0; busy = 1'b0;
      step();
      expect0("R5 immediate done", S_DONE);
      step();
      expect0("R6 idle after done", S_IDLE);
      settle();
   endtask

   task automatic t_long_wait();
      issue = 1'b1; step(); issue = 1'b0;
      absent = 1'b0; busy = 1'b1;
      for (int i = 0; i < 20; i++) begin
         step();
         if (i % 5 == 4) expect0("R4 busy-wait holds", S_ACT);
      end
      busy = 1'b0;
      step();
      expect0("R5 done after wait", S_DONE);
      step();
      expect0("R6 idle after wait", S_IDLE);
      settle();
   endtask

   task automatic t_withdraw();
      issue = 1'b1; step(); issue = 1'b0;
      absent = 1'b0; busy = 1'b1;
      step(); step();
      expect0("R4 waiting before withdrawal", S_ACT);
      absent = 1'b1;
      step();
      expect0("R3 trap on withdrawal", S_TRAP);
      step();
      expect0("R6 idle after withdrawal", S_IDLE);
      settle();
   endtask

   task automatic t_ignore_issue();
      issue = 1'b1; step();
      expect0("R1 request with issue held", S_ACT);
      absent = 1'b0; busy = 1'b1;
      step(); step();
      expect0("R7 issue held in wait", S_ACT);
      busy = 1'b0;
      step();
      expect0("R7 single done", S_DONE);
      issue = 1'b0;
      step();
      expect0("R7 no restart after done", S_IDLE);
      settle();
   endtask

   task automatic t_timeout();
      issue = 1'b1; step(); issue = 1'b0;
      absent = 1'b0; busy = 1'b1;
      step();
      for (int i = 1; i <= 3; i++) begin
         expect1("R8 before limit", S_ACT);
         step();
      end
      expect1("R8 fourth wait cycle", S_ACT);
      step();
      expect1("R8 forced trap", S_TRAP);
      expect0("R4 no timeout when disabled", S_ACT);
      step();
      expect1("R6 idle after forced trap", S_IDLE);
      busy = 1'b0;
      step();
      expect0("R5 default instance completes", S_DONE);
      settle();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_absent_trap();
      t_immediate_done();
      t_long_wait();
      t_withdraw();
      t_ignore_issue();
      t_timeout();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule